// File: doc/BRIEF.md
# Backplane Link Driver Direction Controller

This block decides, cycle by cycle, which way the two differential line drivers of a hot-pluggable module point: one driver for the data pair and one for the clock pair. In the normal synchronous mode the link is half duplex. The side that transmits drives both the data and the clock pair, and one active-low processor transmit enable sets the direction of both drivers. A test-only full-duplex asynchronous mode sends on the clock pair and listens on the data pair. In that mode only the clock driver may turn on.

The module may not drive the backplane unless the host protocol has told it to send. A start command sets a transmit grant. A last-character-done strobe clears the grant at the edge where it is seen, so the line is released at once. An asserted failsafe flag forces both drivers to receive whatever the other inputs say. The block also passes through the host handshake lines. Presence follows select. Select and reset together give a registered hardware reset request. The sync strobe leaves the block only while the host enables it.

Top module: `linkDirCtl`

## Requirements
- R1: In synchronous mode (`cpuAsyncEn`=0), with the grant held, `cpuTxEnN`=0 and `failSafe`=0, both `dataDrvEn` and `clkDrvEn` are 1. If any one of these conditions is missing, both are 0.
- R2: While `failSafe`=1, `dataDrvEn` and `clkDrvEn` are both 0 in the same cycle, whatever the grant, `cpuTxEnN` and the mode.
- R3: In asynchronous mode (`cpuAsyncEn`=1), `dataDrvEn` is always 0. `clkDrvEn` is 1 exactly when the grant is held, `cpuTxEnN`=0 and `failSafe`=0.
- R4: The grant is set at a clock edge where `txStart`=1 and `lastCharDone`=0, and it then holds. Without the grant both drivers stay 0, even with `cpuTxEnN`=0.
- R5: A clock edge with `lastCharDone`=1 clears the grant, so the drivers are 0 from that edge on. This also holds when `txStart`=1 at the same edge.
- R6: `hwResetReq` is 1 in the cycle after an edge where `hostSelect`=1 and `hostReset`=1 are both seen, and 0 after any other edge.
- R7: `present` equals `hostSelect` at all times.
- R8: `syncOut` equals `syncReq` AND `hostSyncEn`.
- R9: `txActiveN` is 0 exactly when at least one of `dataDrvEn` and `clkDrvEn` is 1.
- R10: While `rstN`=0, both driver enables are 0 and `txActiveN` is 1. An edge in reset clears the grant and `hwResetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuTxEnN | input | 1 | Processor transmit enable, active low |
| cpuAsyncEn | input | 1 | Selects full-duplex asynchronous test mode |
| failSafe | input | 1 | Failsafe flag, forces receive |
| txStart | input | 1 | Protocol command to begin transmitting |
| lastCharDone | input | 1 | Strobe: final character has gone out |
| hostSelect | input | 1 | Host module select, active high |
| hostReset | input | 1 | Host reset line, active high |
| hostSyncEn | input | 1 | Host permission for the sync strobe |
| syncReq | input | 1 | Internal sync strobe request |
| dataDrvEn | output | 1 | Data pair driver transmit enable |
| clkDrvEn | output | 1 | Clock pair driver transmit enable |
| txActiveN | output | 1 | Transmitter enabled flag, active low |
| present | output | 1 | Presence indication |
| hwResetReq | output | 1 | Hardware reset request |
| syncOut | output | 1 | Gated sync strobe |

## Verification
Two collisions matter here. The first is a start command and a last-character strobe at the same edge. The bench sets up both while the grant is off and again while it is held, and it expects the grant to end up clear both times. The second is failsafe rising while a granted transmission is driving. The bench sweeps every combination of mode, enable, failsafe and host lines with the grant held and with it clear, and it expects both drivers to turn off in that same cycle.

// File: rtl/linkdir_pkg.sv
package linkdir_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic grant;      // transmit grant held
    logic drive;      // a driver may transmit this cycle
    logic asyncMode;  // full-duplex test mode selected
  } ctrlStrb_t;
endpackage

// File: rtl/lnkCtrl.sv
module lnkCtrl
  import linkdir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txStart,
  input  logic      lastCharDone,
  input  logic      cpuTxEnN,
  input  logic      cpuAsyncEn,
  input  logic      failSafe,
  output ctrlStrb_t strb
);
  logic grantQ;

  // Release has priority over a start arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) grantQ <= 1'b0;
    else if (lastCharDone) grantQ <= 1'b0;
    else if (txStart) grantQ <= 1'b1;
  end

  always_comb begin
    strb.grant     = grantQ;
    strb.drive     = rstN & grantQ & ~cpuTxEnN & ~failSafe;
    strb.asyncMode = cpuAsyncEn;
  end

  // R5: the edge that sees the last character clears the grant
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    lastCharDone |=> !grantQ);
  // R4: no grant appears without a start command
  a_r4_no_grant_uncommanded: assert property (@(posedge clk) disable iff (!rstN)
    (!grantQ && !txStart) |=> !grantQ);
  // R4: a start with no release sets the grant
  a_r4_grant_set: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !lastCharDone) |=> grantQ);
endmodule

// File: rtl/lnkPath.sv
module lnkPath
  import linkdir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  logic      failSafe,
  input  logic      hostSelect,
  input  logic      hostReset,
  input  logic      hostSyncEn,
  input  logic      syncReq,
  output logic      dataDrvEn,
  output logic      clkDrvEn,
  output logic      txActiveN,
  output logic      present,
  output logic      hwResetReq,
  output logic      syncOut
);
  logic resetReqQ;

  // Sync mode drives both pairs; async mode transmits on the clock pair only
  always_comb begin
    clkDrvEn  = strb.drive;
    dataDrvEn = strb.drive & ~strb.asyncMode;
    txActiveN = ~(dataDrvEn | clkDrvEn);
    present   = hostSelect;
    syncOut   = syncReq & hostSyncEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resetReqQ <= 1'b0;
    else resetReqQ <= hostSelect & hostReset;
  end
  assign hwResetReq = resetReqQ;

  // R2: failsafe forces both drivers to receive
  a_r2_failsafe_rx: assert property (@(posedge clk) disable iff (!rstN)
    failSafe |-> (!dataDrvEn && !clkDrvEn));
  // R3: async mode never drives the data pair
  a_r3_async_no_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.asyncMode |-> !dataDrvEn);
  // R4: no driver without a grant
  a_r4_need_grant: assert property (@(posedge clk) disable iff (!rstN)
    !strb.grant |-> (!dataDrvEn && !clkDrvEn));
  // R6: combined select and reset requests a reset on the next cycle
  a_r6_reset_req: assert property (@(posedge clk) disable iff (!rstN)
    (hostSelect && hostReset) |=> hwResetReq);
  // R8: sync leaves only when the host enables it
  a_r8_sync_gate: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |-> hostSyncEn);
endmodule

// File: rtl/linkDirCtl.sv
module linkDirCtl
  import linkdir_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cpuTxEnN,
  input  logic cpuAsyncEn,
  input  logic failSafe,
  input  logic txStart,
  input  logic lastCharDone,
  input  logic hostSelect,
  input  logic hostReset,
  input  logic hostSyncEn,
  input  logic syncReq,
  output logic dataDrvEn,
  output logic clkDrvEn,
  output logic txActiveN,
  output logic present,
  output logic hwResetReq,
  output logic syncOut
);
  ctrlStrb_t strb;

  lnkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .lastCharDone(lastCharDone),
    .cpuTxEnN(cpuTxEnN), .cpuAsyncEn(cpuAsyncEn), .failSafe(failSafe),
    .strb(strb)
  );

  lnkPath uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .failSafe(failSafe),
    .hostSelect(hostSelect), .hostReset(hostReset), .hostSyncEn(hostSyncEn),
    .syncReq(syncReq), .dataDrvEn(dataDrvEn), .clkDrvEn(clkDrvEn),
    .txActiveN(txActiveN), .present(present), .hwResetReq(hwResetReq),
    .syncOut(syncOut)
  );
endmodule

// File: tb/sim_linkDirCtl.sv
module sim_linkDirCtl;
  logic clk = 1'b0;
  logic rstN, cpuTxEnN, cpuAsyncEn, failSafe, txStart, lastCharDone;
  logic hostSelect, hostReset, hostSyncEn, syncReq;
  logic dataDrvEn, clkDrvEn, txActiveN, present, hwResetReq, syncOut;
  int checks = 0;
  int errors = 0;
  logic expGrant, expHw;

  always #2 clk = ~clk;

  linkDirCtl u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs at the falling edge, pass one rising edge, check 1 ns later
  task automatic step(input logic [9:0] v);
    @(negedge clk);
    {cpuAsyncEn, cpuTxEnN, failSafe, txStart, lastCharDone,
     hostSelect, hostReset, hostSyncEn, syncReq, rstN} = v;
    @(posedge clk);
    if (!rstN) begin expGrant = 0; expHw = 0; end
    else begin
      if (lastCharDone) expGrant = 0; else if (txStart) expGrant = 1;
      expHw = hostSelect & hostReset;
    end
    #1;
  endtask

  task automatic checkAll();
    logic drv;
    drv = rstN & expGrant & ~cpuTxEnN & ~failSafe;
    chk(cpuAsyncEn ? "R3 clk" : "R1 clk", clkDrvEn, drv);
    chk(cpuAsyncEn ? "R3 data" : "R1 data", dataDrvEn, drv & ~cpuAsyncEn);
    if (failSafe) chk("R2", clkDrvEn | dataDrvEn, 1'b0);
    chk("R9", txActiveN, ~(drv));
    chk("R7", present, hostSelect);
    chk("R8", syncOut, syncReq & hostSyncEn);
    chk("R6", hwResetReq, expHw);
  endtask

  initial begin
    expGrant = 0; expHw = 0;
    // R10: reset with start and select/reset active
    step(10'b0_0_0_1_0_1_1_0_0_0);
    chk("R10 clk", clkDrvEn, 1'b0);
    chk("R10 data", dataDrvEn, 1'b0);
    chk("R10 txActiveN", txActiveN, 1'b1);
    chk("R10 hw", hwResetReq, 1'b0);
    step(10'b0_0_0_0_0_0_0_0_0_1);
    chk("R10 grant clear", clkDrvEn, 1'b0);
    checkAll();

    // Exhaustive sweep of static inputs, with the grant clear and then held
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 128; p++) begin
        logic [6:0] b;
        b = p[6:0];
        // R4 / R5: set or clear the grant first
        if (g == 1) step(10'b0_1_0_1_0_0_0_0_0_1);
        else step(10'b0_1_0_0_1_0_0_0_0_1);
        step({b[6], b[5], b[4], 1'b0, 1'b0, b[3], b[2], b[1], b[0], 1'b1});
        checkAll();
      end
    end

    // R4: enable low without a grant drives nothing
    step(10'b0_0_0_0_1_0_0_0_0_1);
    step(10'b0_0_0_0_0_0_0_0_0_1);
    chk("R4 no grant", clkDrvEn, 1'b0);
    // R4: start with enable low drives from the next cycle
    step(10'b0_0_0_1_0_0_0_0_0_1);
    chk("R4 granted", dataDrvEn, 1'b1);
    // R5: last character releases at that edge
    step(10'b0_0_0_0_1_0_0_0_0_1);
    chk("R5 release", clkDrvEn, 1'b0);
    // R5: start and done together with the grant clear
    step(10'b0_0_0_1_1_0_0_0_0_1);
    chk("R5 simultaneous idle", clkDrvEn, 1'b0);
    // R5: start and done together with the grant held
    step(10'b0_0_0_1_0_0_0_0_0_1);
    chk("R5 pre-held", clkDrvEn, 1'b1);
    step(10'b0_0_0_1_1_0_0_0_0_1);
    chk("R5 simultaneous held", clkDrvEn, 1'b0);
    // R2: failsafe during an active transmission turns drivers off in that cycle
    step(10'b0_0_0_1_0_0_0_0_0_1);
    @(negedge clk); failSafe = 1'b1; #1;
    chk("R2 same cycle", clkDrvEn | dataDrvEn, 1'b0);
    failSafe = 1'b0; #1;
    chk("R2 recover", clkDrvEn, 1'b1);
    // R10: reset while driving turns drivers off immediately
    rstN = 1'b0; #1;
    chk("R10 immediate", clkDrvEn | dataDrvEn, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule